// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data between one 12-bit narrow port (A) and a wide side made of two 12-bit halves (B1 and B2), which together form a 24-bit word. In the narrow-to-wide direction, each half has its own capture enable. Enabling the two halves on successive clocks places two consecutive A words side by side, so the wide side then shows them as one 24-bit word. In the wide-to-narrow direction, a select input picks which half feeds a single A-side register. That register reloads on every clock.

Every control input is sampled into a register on the rising clock edge first: the capture enables, the select and the three output enables. Every transaction is therefore synchronous, and every change of direction or drive appears one clock after it is presented. Each port's tri-state output is modelled as a data bus plus an active-high drive-enable output. When a port's drive enable is low, its data bus is released to high impedance. The reset is synchronous and active-low. It clears all data and turns every drive enable off.

Top module: `bx_exchanger`

## Requirements
- R1: While reset is held, and after its release until an output enable is sampled active, all three drive enables are low. Both halves and the A register hold zero after reset.
- R2: If `cap1_n` is sampled low together with `a_in` at clock edge k, `b1_out` equals that word after edge k+1.
- R3: If `cap2_n` is sampled low together with `a_in` at clock edge k, `b2_out` equals that word after edge k+1.
- R4: If a half's capture enable is sampled high at edge k, that half keeps its value across edge k+1.
- R5: Capturing word X with `cap1_n` at edge k and word Y with `cap2_n` at edge k+1 shows the 24-bit word {`b2_out`,`b1_out`} = {Y,X} after edge k+2.
- R6: `a_out` after edge k+1 equals `b1_in` sampled at edge k when `sel_b2` sampled at k was 0, and equals `b2_in` sampled at edge k when it was 1. The A register reloads on every clock.
- R7: If both capture enables are sampled low at the same edge, both halves load the same A word.
- R8: `a_oe` after edge k is the inverse of `oea_n` sampled at edge k, so a change of enable shows after exactly one clock. When `a_oe` is low, `a_out` is high impedance.
- R9: `b1_oe` and `b2_oe` follow `oeb1_n` and `oeb2_n` in the same way, each independently of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 12 | Narrow-side input word |
| b1_in | input | 12 | Lower wide-half input word |
| b2_in | input | 12 | Upper wide-half input word |
| cap1_n | input | 1 | Active-low capture enable for the lower half |
| cap2_n | input | 1 | Active-low capture enable for the upper half |
| sel_b2 | input | 1 | Wide-to-narrow select: 0 picks B1, 1 picks B2 |
| oea_n | input | 1 | Active-low output enable, A port |
| oeb1_n | input | 1 | Active-low output enable, lower half |
| oeb2_n | input | 1 | Active-low output enable, upper half |
| a_out | output | 12 | Narrow-side output bus (Z when not driven) |
| a_oe | output | 1 | Narrow-side drive enable, active high |
| b1_out | output | 12 | Lower-half output bus (Z when not driven) |
| b1_oe | output | 1 | Lower-half drive enable, active high |
| b2_out | output | 12 | Upper-half output bus (Z when not driven) |
| b2_oe | output | 1 | Upper-half drive enable, active high |

## Verification
On every cycle, the assertions check the one-clock lag of each drive enable behind its active-low input. They also check the two-clock path from a captured A word to its half, the hold of an unselected half, and the two-clock path from the selected B input to the A register. Only the bench's scenarios show the reset contents, the packing of two consecutive words into one 24-bit value, and the case where both halves capture at once. The same holds for runs of enable toggling and a reset in the middle of operation, whose effect spans more than a single property's window.

// File: rtl/bx_pkg.sv
// bx_pkg: shared control bundle for the exchanger.
// Assumes all control inputs are sampled together on one clock.
package bx_pkg;

    // Registered control word; every field keeps its pin polarity.
    typedef struct packed {
        logic cap1_n;
        logic cap2_n;
        logic sel_b2;
        logic oea_n;
        logic oeb1_n;
        logic oeb2_n;
    } bx_ctl_t;

    // Reset value: captures disabled, select on B1, all drives off.
    localparam bx_ctl_t BX_CTL_IDLE = '{
        cap1_n: 1'b1,
        cap2_n: 1'b1,
        sel_b2: 1'b0,
        oea_n:  1'b1,
        oeb1_n: 1'b1,
        oeb2_n: 1'b1
    };

    // Number of wide-side halves.
    localparam int BX_HALVES = 2;

endpackage

// File: rtl/bx_in_stage.sv
// bx_in_stage: first register stage. Samples the control bundle and all
// three input words on every rising edge.
// Assumes a synchronous active-low reset that returns the control bundle
// to its idle value and the data to zero.
module bx_in_stage
    import bx_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bx_ctl_t           ctl_d,
    input  logic [WORD_W-1:0] a_d,
    input  logic [WORD_W-1:0] b1_d,
    input  logic [WORD_W-1:0] b2_d,
    output bx_ctl_t           ctl_q,
    output logic [WORD_W-1:0] a_q,
    output logic [WORD_W-1:0] b1_q,
    output logic [WORD_W-1:0] b2_q
);

    // Control sampling: all control takes effect one clock after it is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= BX_CTL_IDLE;
        else        ctl_q <= ctl_d;
    end

    // Data sampling: input words are aligned with the control sampled on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q  <= '0;
            b1_q <= '0;
            b2_q <= '0;
        end else begin
            a_q  <= a_d;
            b1_q <= b1_d;
            b2_q <= b2_d;
        end
    end

endmodule

// File: rtl/bx_half_reg.sv
// bx_half_reg: one half of the wide-side storage. Loads the sampled A word
// when its registered active-low load enable is low, and holds otherwise.
// Assumes load_n already comes from a register.
module bx_half_reg #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);

    // Storage: clear on reset, load when enabled, otherwise keep.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (!load_n) q <= d;
    end

endmodule

// File: rtl/bx_a_reg.sv
// bx_a_reg: narrow-side storage. Reloads on every edge with the B word
// chosen by the registered select.
// Assumes sel_b2 and both inputs come from the same register stage.
module bx_a_reg #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_b2,
    input  logic [WORD_W-1:0] b1,
    input  logic [WORD_W-1:0] b2,
    output logic [WORD_W-1:0] q
);

    logic [WORD_W-1:0] pick;

    // Source choice between the two halves.
    always_comb pick = sel_b2 ? b2 : b1;

    // Storage: clear on reset, reload every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= pick;
    end

endmodule

// File: rtl/bx_tri_drv.sv
// bx_tri_drv: models a tri-state output as a data bus that floats when
// its active-high drive enable is low.
// Assumes drive comes from a register, so the bus never glitches between edges.
module bx_tri_drv #(
    parameter int WORD_W = 12
) (
    input  logic              drive,
    input  logic [WORD_W-1:0] val,
    output logic [WORD_W-1:0] pin
);

    // Bus release when not driving.
    assign pin = drive ? val : {WORD_W{1'bz}};

endmodule

// File: rtl/bx_exchanger.sv
// bx_exchanger: registered exchanger between a narrow port and a wide side
// built from two halves. Control and data pass through an input register
// stage; the halves and the narrow register form the second stage.
// Assumes one clock domain and a synchronous active-low reset.
module bx_exchanger
    import bx_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] a_in,
    input  logic [WORD_W-1:0] b1_in,
    input  logic [WORD_W-1:0] b2_in,
    input  logic              cap1_n,
    input  logic              cap2_n,
    input  logic              sel_b2,
    input  logic              oea_n,
    input  logic              oeb1_n,
    input  logic              oeb2_n,
    output logic [WORD_W-1:0] a_out,
    output logic              a_oe,
    output logic [WORD_W-1:0] b1_out,
    output logic              b1_oe,
    output logic [WORD_W-1:0] b2_out,
    output logic              b2_oe
);

    localparam int WIDE_W = WORD_W * BX_HALVES;

    bx_ctl_t                            ctl_d;
    bx_ctl_t                            ctl_q;
    logic [WORD_W-1:0]                  a_q;
    logic [WORD_W-1:0]                  b1_q;
    logic [WORD_W-1:0]                  b2_q;
    logic [BX_HALVES-1:0]               half_load_n;
    logic [BX_HALVES-1:0][WORD_W-1:0]   half_q;
    logic [WIDE_W-1:0]                  wide_word;
    logic [WORD_W-1:0]                  a_reg_q;

    // Gather the control pins into one bundle.
    always_comb begin
        ctl_d.cap1_n = cap1_n;
        ctl_d.cap2_n = cap2_n;
        ctl_d.sel_b2 = sel_b2;
        ctl_d.oea_n  = oea_n;
        ctl_d.oeb1_n = oeb1_n;
        ctl_d.oeb2_n = oeb2_n;
    end

    bx_in_stage #(.WORD_W(WORD_W)) u_in (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl_d (ctl_d),
        .a_d   (a_in),
        .b1_d  (b1_in),
        .b2_d  (b2_in),
        .ctl_q (ctl_q),
        .a_q   (a_q),
        .b1_q  (b1_q),
        .b2_q  (b2_q)
    );

    // Map the registered capture enables onto the half index.
    always_comb begin
        half_load_n[0] = ctl_q.cap1_n;
        half_load_n[1] = ctl_q.cap2_n;
    end

    // One storage register per wide half, all fed from the sampled A word.
    for (genvar g = 0; g < BX_HALVES; g++) begin : g_half
        bx_half_reg #(.WORD_W(WORD_W)) u_half (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_n (half_load_n[g]),
            .d      (a_q),
            .q      (half_q[g])
        );
    end

    // The two halves seen as one wide word; upper half is B2.
    assign wide_word = half_q;

    bx_a_reg #(.WORD_W(WORD_W)) u_areg (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_b2 (ctl_q.sel_b2),
        .b1     (b1_q),
        .b2     (b2_q),
        .q      (a_reg_q)
    );

    // Drive enables come straight from the registered active-low enables.
    assign a_oe  = ~ctl_q.oea_n;
    assign b1_oe = ~ctl_q.oeb1_n;
    assign b2_oe = ~ctl_q.oeb2_n;

    bx_tri_drv #(.WORD_W(WORD_W)) u_drv_a (
        .drive (a_oe),
        .val   (a_reg_q),
        .pin   (a_out)
    );

    bx_tri_drv #(.WORD_W(WORD_W)) u_drv_b1 (
        .drive (b1_oe),
        .val   (wide_word[WORD_W-1:0]),
        .pin   (b1_out)
    );

    bx_tri_drv #(.WORD_W(WORD_W)) u_drv_b2 (
        .drive (b2_oe),
        .val   (wide_word[WIDE_W-1:WORD_W]),
        .pin   (b2_out)
    );

endmodule

// File: rtl/bx_exchanger_chk.sv
// bx_exchanger_chk: port-level properties of the exchanger, bound to it.
// Assumes only the top-level pins; data is compared only while driven.
module bx_exchanger_chk #(
    parameter int WORD_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] a_in,
    input logic [WORD_W-1:0] b1_in,
    input logic [WORD_W-1:0] b2_in,
    input logic              cap1_n,
    input logic              cap2_n,
    input logic              sel_b2,
    input logic              oea_n,
    input logic              oeb1_n,
    input logic              oeb2_n,
    input logic [WORD_W-1:0] a_out,
    input logic              a_oe,
    input logic [WORD_W-1:0] b1_out,
    input logic              b1_oe,
    input logic [WORD_W-1:0] b2_out,
    input logic              b2_oe
);

    AST_OEA_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (a_oe == !$past(oea_n)));  // R8

    AST_OEB1_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (b1_oe == !$past(oeb1_n)));  // R9

    AST_OEB2_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (b2_oe == !$past(oeb2_n)));  // R9

    AST_B1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$past(cap1_n, 2) && b1_oe)
        |-> (b1_out == $past(a_in, 2)));  // R2

    AST_B2_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$past(cap2_n, 2) && b2_oe)
        |-> (b2_out == $past(a_in, 2)));  // R3

    AST_B1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(cap1_n, 2) && b1_oe && $past(b1_oe))
        |-> $stable(b1_out));  // R4

    AST_B2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(cap2_n, 2) && b2_oe && $past(b2_oe))
        |-> $stable(b2_out));  // R4

    AST_A_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && a_oe)
        |-> (a_out == ($past(sel_b2, 2) ? $past(b2_in, 2) : $past(b1_in, 2))));  // R6

endmodule

bind bx_exchanger bx_exchanger_chk #(.WORD_W(WORD_W)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_in   (a_in),
    .b1_in  (b1_in),
    .b2_in  (b2_in),
    .cap1_n (cap1_n),
    .cap2_n (cap2_n),
    .sel_b2 (sel_b2),
    .oea_n  (oea_n),
    .oeb1_n (oeb1_n),
    .oeb2_n (oeb2_n),
    .a_out  (a_out),
    .a_oe   (a_oe),
    .b1_out (b1_out),
    .b1_oe  (b1_oe),
    .b2_out (b2_out),
    .b2_oe  (b2_oe)
);

// File: tb/test_bx_exchanger.sv
// test_bx_exchanger: scoreboard bench. The driver task applies one cycle of
// stimulus and pushes the expected port values with their due cycle; the
// monitor pops and compares them at the falling edge of that cycle.
module test_bx_exchanger;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic         cap1_n = 1'b1, cap2_n = 1'b1, sel_b2 = 1'b0;
    logic         oea_n = 1'b1, oeb1_n = 1'b1, oeb2_n = 1'b1;
    wire  [W-1:0] a_out, b1_out, b2_out;
    wire          a_oe, b1_oe, b2_oe;

    bx_exchanger #(.WORD_W(W)) i_bx_exchanger (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b1_in(b1_in), .b2_in(b2_in),
        .cap1_n(cap1_n), .cap2_n(cap2_n), .sel_b2(sel_b2),
        .oea_n(oea_n), .oeb1_n(oeb1_n), .oeb2_n(oeb2_n),
        .a_out(a_out), .a_oe(a_oe), .b1_out(b1_out), .b1_oe(b1_oe),
        .b2_out(b2_out), .b2_oe(b2_oe)
    );

    always #2 clk = ~clk;   // 250 MHz

    // Port ids: 0 a_out, 1 b1_out, 2 b2_out, 3 a_oe, 4 b1_oe, 5 b2_oe
    typedef struct {
        int           due;
        int           port;
        logic [W-1:0] val;
        string        tag;
    } exp_t;

    exp_t   sb[$];
    int     cyc = 0;
    int     checks = 0;
    int     errors = 0;
    logic [W-1:0] m_b1 = '0, m_b2 = '0;
    bit     m_b1_fresh = 1, m_b2_fresh = 1, last_only1 = 0;
    logic [W-1:0] last_b1_word = '0;
    bit     done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int due, input int port, input logic [W-1:0] val, input string tag);
        exp_t e;
        e.due = due; e.port = port; e.val = val; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic report(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Monitor: compare every item due this cycle, away from the rising edge.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                logic [W-1:0] act;
                bit           drv;
                drv = 1'b1;
                case (sb[i].port)
                    0: begin act = a_out;  drv = a_oe;  end
                    1: begin act = b1_out; drv = b1_oe; end
                    2: begin act = b2_out; drv = b2_oe; end
                    3: act = {{(W-1){1'b0}}, a_oe};
                    4: act = {{(W-1){1'b0}}, b1_oe};
                    default: act = {{(W-1){1'b0}}, b2_oe};
                endcase
                if (drv) report(act == sb[i].val, sb[i].tag, act, sb[i].val);
                sb.delete(i);
            end
        end
    end

    // Driver: one cycle of stimulus plus the expected results it implies.
    task automatic step(input logic [W-1:0] a, input logic [W-1:0] b1, input logic [W-1:0] b2,
                        input logic c1n, input logic c2n, input logic sel,
                        input logic oan, input logic ob1n, input logic ob2n);
        int n;
        @(negedge clk); #1;
        a_in = a; b1_in = b1; b2_in = b2;
        cap1_n = c1n; cap2_n = c2n; sel_b2 = sel;
        oea_n = oan; oeb1_n = ob1n; oeb2_n = ob2n;
        n = cyc;
        push(n + 1, 3, {{(W-1){1'b0}}, ~oan},  "R8");
        push(n + 1, 4, {{(W-1){1'b0}}, ~ob1n}, "R9");
        push(n + 1, 5, {{(W-1){1'b0}}, ~ob2n}, "R9");
        push(n + 2, 0, sel ? b2 : b1, "R6");
        if (!c1n) begin
            m_b1 = a;
            push(n + 2, 1, m_b1, !c2n ? "R7" : "R2");
        end else begin
            push(n + 2, 1, m_b1, m_b1_fresh ? "R1" : "R4");
        end
        if (!c2n) begin
            m_b2 = a;
            push(n + 2, 2, m_b2, !c1n ? "R7" : (last_only1 ? "R5" : "R3"));
            if (last_only1 && c1n) push(n + 2, 1, last_b1_word, "R5");
        end else begin
            push(n + 2, 2, m_b2, m_b2_fresh ? "R1" : "R4");
        end
        if (!c1n) m_b1_fresh = 0;
        if (!c2n) m_b2_fresh = 0;
        last_only1 = !c1n && c2n;
        if (!c1n) last_b1_word = a;
    endtask

    // Reset: hold two cycles, check drives are off, then release.
    task automatic do_reset();
        @(negedge clk); #1;
        rst_n = 0;
        a_in = '0; b1_in = '0; b2_in = '0;
        cap1_n = 1; cap2_n = 1; sel_b2 = 0;
        oea_n = 0; oeb1_n = 0; oeb2_n = 0;   // enables asked for, reset must win
        repeat (2) @(negedge clk);
        sb.delete();
        report(!a_oe && !b1_oe && !b2_oe, "R1", {9'd0, a_oe, b1_oe, b2_oe}, '0);
        #1;
        rst_n = 1;
        oea_n = 1; oeb1_n = 1; oeb2_n = 1;
        m_b1 = '0; m_b2 = '0; m_b1_fresh = 1; m_b2_fresh = 1;
        last_only1 = 0; last_b1_word = '0;
        @(negedge clk);
        report(!a_oe && !b1_oe && !b2_oe, "R1", {9'd0, a_oe, b1_oe, b2_oe}, '0);
    endtask

    initial begin
        do_reset();
        // Drives on, no capture: reset contents visible.
        step(12'h000, 12'h000, 12'h000, 1, 1, 0, 0, 0, 0);
        step(12'h000, 12'h000, 12'h000, 1, 1, 0, 0, 0, 0);
        // Pack two consecutive words.
        step(12'hA5C, 12'h111, 12'h222, 0, 1, 0, 0, 0, 0);
        step(12'h3B7, 12'h333, 12'h444, 1, 0, 1, 0, 0, 0);
        step(12'hFFF, 12'h555, 12'h666, 1, 1, 0, 0, 0, 0);
        step(12'h0F0, 12'h777, 12'h888, 1, 1, 1, 0, 0, 0);
        // Both halves at once.
        step(12'h9C3, 12'hABC, 12'hDEF, 0, 0, 1, 0, 0, 0);
        step(12'h001, 12'h123, 12'h456, 1, 1, 0, 0, 0, 0);
        // Enable toggling, independent halves.
        step(12'h002, 12'h800, 12'h801, 1, 1, 1, 1, 0, 1);
        step(12'h003, 12'h802, 12'h803, 1, 1, 0, 0, 1, 0);
        step(12'h004, 12'h804, 12'h805, 0, 1, 1, 1, 1, 0);
        step(12'h005, 12'h806, 12'h807, 1, 1, 0, 0, 0, 1);
        step(12'h006, 12'h808, 12'h809, 1, 0, 1, 0, 0, 0);
        step(12'h007, 12'h80A, 12'h80B, 1, 1, 0, 0, 0, 0);
        // Walking patterns through the A path and the halves.
        for (int i = 0; i < 12; i++) begin
            step(12'(1 << i), 12'(~(1 << i)), 12'(1 << i), (i % 3) != 0, (i % 3) != 1,
                 i[0], 0, (i % 5) == 4, (i % 4) == 3);
        end
        // Pack again, then reset mid-run.
        step(12'h5A5, 12'h000, 12'hFFF, 0, 1, 1, 0, 0, 0);
        step(12'hA5A, 12'hFFF, 12'h000, 1, 0, 0, 0, 0, 0);
        step(12'h000, 12'h000, 12'h000, 1, 1, 0, 0, 0, 0);
        step(12'h000, 12'h000, 12'h000, 1, 1, 0, 0, 0, 0);
        do_reset();
        step(12'h000, 12'h000, 12'h000, 1, 1, 0, 0, 0, 0);
        step(12'h000, 12'h000, 12'h000, 1, 1, 0, 0, 0, 0);
        step(12'h000, 12'h000, 12'h000, 1, 1, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        #1;
        report(sb.size() == 0, "R1", 12'(sb.size()), '0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run ends as a failed check.
    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule